// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

A memory-mapped peripheral holding two independent 32-bit down-counters that run on the peripheral clock. While its enable bit is set, a counter steps down by one each clock, so software sees a falling value. Software may write a counter directly, which arms a one-shot delay, or let it reload from its own reload register each time it runs past zero. With all ones loaded into both registers, a counter becomes a free-running wrap-around time base.

Each expiry latches a per-timer flag in a shared cause register. A mask register gates each flag onto that timer's own interrupt line. Flags are acknowledged by writing zero to them. Register access uses a simple single-cycle bus: writes take effect at the clock edge, and reads return data combinationally from the address.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, every register reads zero: control, both reload registers, both counters, cause and mask. Both interrupt outputs are low.
- R2: Control register at byte address 0x000. Timer 0 uses bit 0 as enable and bit 1 as reload enable. Timer 1 uses bit 2 as enable and bit 3 as reload enable. An enabled counter that is not at zero drops by exactly one per clock. A disabled counter holds its value.
- R3: Writing a counter's value register loads that counter at the same edge. The load overrides that edge's decrement or expiry. Any value from 0 to 0xFFFFFFFE is accepted as a delta.
- R4: With reload enabled, an enabled counter at zero expires and reloads from its reload register at the next edge. A reload value R therefore gives a period of R+1 clocks. Reload all ones and count zero give a wrap to 0xFFFFFFFF.
- R5: With reload disabled, an enabled counter at zero expires once and then stays at zero. Its cause bit is not set again until the counter is written.
- R6: Cause register at 0x110. Bit 1 is timer 0 and bit 2 is timer 1. A timer's bit becomes 1 at the edge where that timer expires.
- R7: A write to the cause register clears the bits written as 0 and keeps the bits written as 1.
- R8: Mask register at 0x114, with the same bit positions as the cause register. Interrupt output i (bit 0 for timer 0, bit 1 for timer 1) is high exactly while cause bit and mask bit of that timer are both 1.
- R9: When a cause write clears a bit at the same edge that timer expires, the bit ends up 1.
- R10: Reload registers at 0x010 (timer 0) and 0x018 (timer 1) and value registers at 0x014 and 0x01C read back what they hold. Any other address reads zero.
- R11: The two timers are independent. Running, loading or expiring one leaves the other's count and cause bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irqOut | output | 2 | Per-timer interrupt, bit 0 timer 0, bit 1 timer 1 |

## Verification
A counter that loses or gains a step shows up at the next value read as an off-by-N count. It also moves the next cause bit by the same number of edges, so each expiry is checked at the exact edge it is due and one edge before it. A stuck one-shot latch or a wrong write-keep mask shows up at the cause register within one edge of the write or expiry that should have changed it. Random loads and waits hit the decrement and load paths at many values. Directed cases cover the wrap, the largest delta and the collision of an acknowledge with an expiry.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CNT_W       = 32;
  localparam int TIMER_COUNT = 2;
  localparam int ADDR_W      = 12;
  localparam int DATA_W      = CNT_W;
  localparam int CTRL_W      = 2 * TIMER_COUNT;

  // address map (byte addresses)
  localparam int CTRL_ADDR   = 'h000;
  localparam int RELOAD_BASE = 'h010;
  localparam int VALUE_BASE  = 'h014;
  localparam int SLOT_STRIDE = 8;
  localparam int CAUSE_ADDR  = 'h110;
  localparam int MASK_ADDR   = 'h114;
  localparam int CAUSE_LSB   = 1;

  typedef struct packed {
    logic                   ctrlWr;
    logic                   causeWr;
    logic                   maskWr;
    logic [TIMER_COUNT-1:0] reloadWr;
    logic [TIMER_COUNT-1:0] valueWr;
    logic [DATA_W-1:0]      wdata;
  } strobe_t;
endpackage

// File: rtl/dct_regctl.sv
module dct_regctl
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CTRL_W-1:0] ctrlQ,
  input  logic [CNT_W-1:0]  countQ  [TIMER_COUNT],
  input  logic [CNT_W-1:0]  reloadQ [TIMER_COUNT],
  input  logic [TIMER_COUNT-1:0] causeQ,
  input  logic [TIMER_COUNT-1:0] maskQ,
  output strobe_t           stb,
  output logic [DATA_W-1:0] busRdata
);
  logic wrEn;
  assign wrEn = busSel && busWrite;

  // write decode
  always_comb begin
    stb          = '0;
    stb.wdata    = busWdata;
    stb.ctrlWr   = wrEn && (busAddr == ADDR_W'(CTRL_ADDR));
    stb.causeWr  = wrEn && (busAddr == ADDR_W'(CAUSE_ADDR));
    stb.maskWr   = wrEn && (busAddr == ADDR_W'(MASK_ADDR));
    for (int i = 0; i < TIMER_COUNT; i++) begin
      stb.reloadWr[i] = wrEn && (busAddr == ADDR_W'(RELOAD_BASE + SLOT_STRIDE * i));
      stb.valueWr[i]  = wrEn && (busAddr == ADDR_W'(VALUE_BASE + SLOT_STRIDE * i));
    end
  end

  // read mux, R10
  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(CTRL_ADDR))
      busRdata[CTRL_W-1:0] = ctrlQ;
    if (busAddr == ADDR_W'(CAUSE_ADDR))
      busRdata[CAUSE_LSB +: TIMER_COUNT] = causeQ;
    if (busAddr == ADDR_W'(MASK_ADDR))
      busRdata[CAUSE_LSB +: TIMER_COUNT] = maskQ;
    for (int i = 0; i < TIMER_COUNT; i++) begin
      if (busAddr == ADDR_W'(RELOAD_BASE + SLOT_STRIDE * i))
        busRdata = reloadQ[i];
      if (busAddr == ADDR_W'(VALUE_BASE + SLOT_STRIDE * i))
        busRdata = countQ[i];
    end
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ctrlWr, stb.causeWr, stb.maskWr, stb.reloadWr, stb.valueWr}));
endmodule

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  output logic [CTRL_W-1:0]      ctrlQ,
  output logic [CNT_W-1:0]       countQ  [TIMER_COUNT],
  output logic [CNT_W-1:0]       reloadQ [TIMER_COUNT],
  output logic [TIMER_COUNT-1:0] causeQ,
  output logic [TIMER_COUNT-1:0] maskQ,
  output logic [TIMER_COUNT-1:0] irqOut
);
  logic [TIMER_COUNT-1:0] expire;
  logic [TIMER_COUNT-1:0] keepBits;
  logic [TIMER_COUNT-1:0] timerEn;
  logic [TIMER_COUNT-1:0] reloadEn;
  logic                   spentQ [TIMER_COUNT];

  // shared control and mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      maskQ <= '0;
    end else begin
      if (stb.ctrlWr) ctrlQ <= stb.wdata[CTRL_W-1:0];
      if (stb.maskWr) maskQ <= stb.wdata[CAUSE_LSB +: TIMER_COUNT];
    end
  end

  // cause: written zeros clear, new expiry wins
  assign keepBits = stb.causeWr ? stb.wdata[CAUSE_LSB +: TIMER_COUNT] : '1;

  always_ff @(posedge clk) begin
    if (!rstN) causeQ <= '0;
    else       causeQ <= (causeQ & keepBits) | expire;
  end

  assign irqOut = causeQ & maskQ;

  for (genvar i = 0; i < TIMER_COUNT; i++) begin : g_timer
    assign timerEn[i]  = ctrlQ[2*i];
    assign reloadEn[i] = ctrlQ[2*i+1];
    assign expire[i]   = timerEn[i] && (countQ[i] == '0) && !spentQ[i] && !stb.valueWr[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reloadQ[i] <= '0;
      end else if (stb.reloadWr[i]) begin
        reloadQ[i] <= stb.wdata[CNT_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        countQ[i] <= '0;
        spentQ[i] <= 1'b0;
      end else if (stb.valueWr[i]) begin
        countQ[i] <= stb.wdata[CNT_W-1:0];
        spentQ[i] <= 1'b0;
      end else if (expire[i]) begin
        if (reloadEn[i]) countQ[i] <= reloadQ[i];
        else             spentQ[i] <= 1'b1;
      end else if (timerEn[i] && countQ[i] != '0) begin
        countQ[i] <= countQ[i] - 1'b1;
      end
    end

    // R2
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(timerEn[i] && countQ[i] != '0 && !stb.valueWr[i]) |->
        countQ[i] == $past(countQ[i]) - 1'b1);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(!timerEn[i] && !stb.valueWr[i]) |-> countQ[i] == $past(countQ[i]));

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(stb.valueWr[i]) |-> countQ[i] == $past(stb.wdata[CNT_W-1:0]));

    // R4
    cnt_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(timerEn[i] && reloadEn[i] && countQ[i] == '0 && !stb.valueWr[i]) |->
        countQ[i] == $past(reloadQ[i]));

    // R5
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(timerEn[i] && !reloadEn[i] && countQ[i] == '0 && !stb.valueWr[i]) |->
        countQ[i] == '0);

    // R6
    cause_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(expire[i]) |-> causeQ[i]);

    // R7
    cause_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(causeQ[i]) |-> $past(stb.causeWr && !stb.wdata[CAUSE_LSB + i]));
  end
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import dct_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic [TIMER_COUNT-1:0] irqOut
);
  strobe_t                stb;
  logic [CTRL_W-1:0]      ctrlQ;
  logic [CNT_W-1:0]       countQ  [TIMER_COUNT];
  logic [CNT_W-1:0]       reloadQ [TIMER_COUNT];
  logic [TIMER_COUNT-1:0] causeQ;
  logic [TIMER_COUNT-1:0] maskQ;

  dct_regctl u_regctl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .ctrlQ    (ctrlQ),
    .countQ   (countQ),
    .reloadQ  (reloadQ),
    .causeQ   (causeQ),
    .maskQ    (maskQ),
    .stb      (stb),
    .busRdata (busRdata)
  );

  dct_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .ctrlQ   (ctrlQ),
    .countQ  (countQ),
    .reloadQ (reloadQ),
    .causeQ  (causeQ),
    .maskQ   (maskQ),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/dual_countdown_timer_bench.sv
`timescale 1ns/1ps
module dual_countdown_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irqOut;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  done = 1'b0;

  localparam logic [11:0] A_CTRL = 12'h000, A_REL0 = 12'h010, A_VAL0 = 12'h014,
                          A_REL1 = 12'h018, A_VAL1 = 12'h01C,
                          A_CAUSE = 12'h110, A_MASK = 12'h114;

  dual_countdown_timer u_dual_countdown_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] expCount(input logic [31:0] start, input int steps);
    return start - 32'(steps);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called in the low phase; captured at the next rising edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkReg(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    edges(3);
    rstN = 1'b1;
    edges(1);

    // R1 reset state
    checkReg("R1 ctrl", A_CTRL, 0);
    checkReg("R1 rel0", A_REL0, 0);
    checkReg("R1 val0", A_VAL0, 0);
    checkReg("R1 rel1", A_REL1, 0);
    checkReg("R1 val1", A_VAL1, 0);
    checkReg("R1 cause", A_CAUSE, 0);
    checkReg("R1 mask", A_MASK, 0);
    check("R1 irq", 32'(irqOut), 0);

    // R3 load while disabled, R2 hold
    wr(A_VAL0, 100);
    checkReg("R3 load", A_VAL0, 100);
    edges(5);
    checkReg("R2 disabled hold", A_VAL0, 100);
    wr(A_CTRL, 32'h1);
    checkReg("R2 ctrl readback", A_CTRL, 1);
    checkReg("R2 enable edge", A_VAL0, 100);
    edges(10);
    checkReg("R2 decrement", A_VAL0, expCount(100, 10));

    // R5 one-shot, R6, R8
    wr(A_CTRL, 0);
    wr(A_VAL0, 5);
    wr(A_MASK, 32'h6);
    wr(A_CAUSE, 0);
    wr(A_CTRL, 32'h1);
    edges(5);
    checkReg("R5 reach zero", A_VAL0, 0);
    checkReg("R6 not yet", A_CAUSE, 0);
    edges(1);
    checkReg("R6 cause timer0 bit1", A_CAUSE, 32'h2);
    check("R8 irq0", 32'(irqOut), 1);
    edges(10);
    checkReg("R5 holds zero", A_VAL0, 0);
    wr(A_CAUSE, 32'hFFFF_FFFD);
    edges(10);
    checkReg("R5 no second expiry", A_CAUSE, 0);
    check("R8 irq low", 32'(irqOut), 0);
    wr(A_VAL0, 2);
    edges(2);
    checkReg("R5 rearm not yet", A_CAUSE, 0);
    edges(1);
    checkReg("R5 rearm expiry", A_CAUSE, 32'h2);

    // R4 periodic timer1, R11
    wr(A_CTRL, 0);
    wr(A_REL1, 7);
    wr(A_VAL1, 7);
    wr(A_CAUSE, 0);
    wr(A_CTRL, 32'hC);
    edges(7);
    checkReg("R4 at zero", A_VAL1, 0);
    checkReg("R4 cause before", A_CAUSE, 0);
    edges(1);
    checkReg("R4 reloaded", A_VAL1, 7);
    checkReg("R6 cause timer1 bit2", A_CAUSE, 32'h4);
    check("R8 irq1", 32'(irqOut), 2);
    wr(A_CAUSE, 32'hFFFF_FFFB);
    edges(6);
    checkReg("R4 period mid", A_CAUSE, 0);
    edges(1);
    checkReg("R4 period R+1", A_CAUSE, 32'h4);
    checkReg("R4 reload again", A_VAL1, 7);
    wr(A_MASK, 32'h2);
    check("R8 masked", 32'(irqOut), 0);
    checkReg("R11 timer0 untouched", A_VAL0, 0);
    checkReg("R11 cause0 untouched", A_CAUSE, 32'h4);

    // R7 selective acknowledge
    wr(A_CTRL, 0);
    wr(A_MASK, 32'h6);
    wr(A_CAUSE, 0);
    wr(A_VAL0, 0);
    wr(A_VAL1, 0);
    wr(A_CTRL, 32'h5);
    edges(1);
    checkReg("R7 both set", A_CAUSE, 32'h6);
    check("R8 both irq", 32'(irqOut), 3);
    wr(A_CAUSE, 32'hFFFF_FFFB);
    checkReg("R7 clear only bit2", A_CAUSE, 32'h2);
    check("R8 irq after ack", 32'(irqOut), 1);

    // R9 collision of acknowledge and expiry
    wr(A_CTRL, 32'h1);
    wr(A_VAL0, 0);
    wr(A_CAUSE, 0);
    checkReg("R9 expiry wins", A_CAUSE, 32'h2);

    // R4 wrap
    wr(A_CTRL, 0);
    wr(A_REL0, 32'hFFFF_FFFF);
    wr(A_VAL0, 0);
    wr(A_CTRL, 32'h3);
    edges(1);
    checkReg("R4 wrap", A_VAL0, 32'hFFFF_FFFF);
    edges(1);
    checkReg("R4 after wrap", A_VAL0, 32'hFFFF_FFFE);

    // R3 largest delta
    wr(A_CTRL, 32'h1);
    wr(A_VAL0, 32'hFFFF_FFFE);
    edges(3);
    checkReg("R3 max delta", A_VAL0, expCount(32'hFFFF_FFFE, 3));

    // R10 unmapped
    checkReg("R10 unmapped 0x020", 12'h020, 0);
    checkReg("R10 unmapped 0x118", 12'h118, 0);

    // random loads and waits, R3 R2 R10
    for (int k = 0; k < 20; k++) begin
      logic [31:0] v;
      logic [31:0] r;
      int n;
      v = 32'd1000 + ($urandom % 32'hFFFF_FC00);
      n = int'($urandom % 50);
      r = $urandom;
      wr(A_VAL0, v);
      edges(n);
      checkReg("R3 random count", A_VAL0, expCount(v, n));
      wr(A_REL1, r);
      checkReg("R10 reload readback", A_REL1, r);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule